// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit holds the modem-control and modem-status state of a 16550-style serial port. It drives four outgoing handshake lines (request-to-send, data-terminal-ready and two general outputs) from a small control register. It samples four incoming lines that are already synchronised: clear-to-send, data-set-ready, carrier detect and ring indicator. For each incoming line it keeps the current level and a sticky change flag. Any set change flag raises a modem-status interrupt request when that interrupt is enabled.

Software reaches both registers through a byte-wide port with one select bit. Reading the status register returns the levels and change flags, then clears the change flags. A loopback mode, set in the control register, cuts the unit off from the outside world. All outgoing lines go inactive, incoming lines are ignored, and the status register shows the control outputs wired back onto the input positions.

Top module: `modem_line_unit`

## Requirements
- R1: After reset the status register reads 0xB0 (carrier, data-set-ready and clear-to-send high, no change flags), the control register reads 0x08, `out2Out` is 1, the other three outgoing lines are 0 and `msIrq` is 0.
- R2: A control write (`regSel`=0) keeps only `wrData[4:0]`, and a read returns bits 7..5 as zero. Bit 0 drives `dtrOut`, bit 1 `rtsOut`, bit 2 `out1Out`, bit 3 `out2Out`, and bit 4 selects loopback. The outputs change at the clock edge that takes the write.
- R3: Status register layout: bit 7 carrier, bit 6 ring, bit 5 data-set-ready, bit 4 clear-to-send. The upper nibble shows the levels sampled at the previous clock edge.
- R4: A change in either direction of clear-to-send, data-set-ready or carrier sets status bit 0, 1 or 3 respectively. The bit stays set until it is cleared.
- R5: Status bit 2 is set only when the ring line falls from 1 to 0. A rising ring line leaves it unchanged.
- R6: A status read (`rdEn`=1, `regSel`=1, not in loopback) returns the value held before the edge and clears bits 3..0 at that edge. A line change sampled at the same edge is still recorded.
- R7: `msIrq` is 1 exactly when `msIntEn` is 1 and any of status bits 3..0 is set.
- R8: In loopback all four outgoing lines are 0 and the incoming lines are ignored: no level or change flag is updated. A status read returns control bit 3 at bit 7, bit 2 at bit 6, bit 0 at bit 5 and bit 1 at bit 4, with bits 3..0 zero.
- R9: Change flags stored before loopback is entered survive status reads made during loopback and can be read after loopback is left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 1 | 0 selects the control register, 1 the status register |
| wrEn | input | 1 | Write strobe (control register only) |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe; a status read clears the change flags |
| rdData | output | 8 | Read data for the selected register |
| msIntEn | input | 1 | Modem-status interrupt enable |
| ctsIn | input | 1 | Clear-to-send line |
| dsrIn | input | 1 | Data-set-ready line |
| dcdIn | input | 1 | Carrier-detect line |
| riIn | input | 1 | Ring-indicator line |
| rtsOut | output | 1 | Request-to-send line |
| dtrOut | output | 1 | Data-terminal-ready line |
| out1Out | output | 1 | General output 1 |
| out2Out | output | 1 | General output 2 |
| msIrq | output | 1 | Modem-status interrupt request |

## Verification
Line levels and change flags are registered once, so a line change is visible on `rdData` and `msIrq` one edge after the line moves. Control writes reach the outgoing lines at the edge that takes the write. `rdData` depends only on registers and the select bit, so a read shows the value from before its edge, and the read's clearing effect shows after that edge. The bench drives every stimulus on the falling edge and samples just after a later falling edge, so each result is checked half a cycle after the edge that produces it. The same-edge case drives a status read and a line change in one cycle and checks both effects after that single edge.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int REG_W     = 8;
  localparam int NLINES    = 4;
  localparam int CTRL_BITS = 5;

  // incoming line index (status bit = index + NLINES for level, index for flag)
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  // control register bit positions
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_OUT1 = 2;
  localparam int CB_OUT2 = 3;
  localparam int CB_LOOP = 4;

  localparam logic [NLINES-1:0]    LINE_RST = 4'b1011;
  localparam logic [CTRL_BITS-1:0] CTRL_RST = 5'b01000;

  typedef struct packed {
    logic wrCtrl;
    logic clrDelta;
    logic sampleLines;
  } mdmStrobe_t;
endpackage

// File: rtl/mdm_control.sv
module mdm_control
  import mdm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       regSel,
  input  logic       loopMode,
  output mdmStrobe_t stb
);
  always_comb begin
    stb.wrCtrl      = wrEn & ~regSel;
    stb.clrDelta    = rdEn & regSel & ~loopMode;
    stb.sampleLines = ~loopMode;
  end

  // R6: a status read outside loopback always issues a clear strobe
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel && !loopMode) |-> stb.clrDelta);
endmodule

// File: rtl/mdm_datapath.sv
module mdm_datapath
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mdmStrobe_t        stb,
  input  logic              regSel,
  input  logic [REG_W-1:0]  wrData,
  input  logic [NLINES-1:0] lineIn,
  output logic [REG_W-1:0]  rdData,
  output logic              loopMode,
  output logic [NLINES-1:0] deltaQ,
  output logic              dtrPin,
  output logic              rtsPin,
  output logic              out1Pin,
  output logic              out2Pin
);
  logic [CTRL_BITS-1:0] ctrlQ;
  logic [NLINES-1:0]    lineQ;
  logic [NLINES-1:0]    chg;
  logic [REG_W-1:0]     loopView;

  assign loopMode = ctrlQ[CB_LOOP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= CTRL_RST;
    else if (stb.wrCtrl) ctrlQ <= wrData[CTRL_BITS-1:0];
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_chg
    if (i == LN_RI) begin : g_trail
      assign chg[i] = stb.sampleLines & lineQ[i] & ~lineIn[i];
    end else begin : g_any
      assign chg[i] = stb.sampleLines & (lineQ[i] ^ lineIn[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ  <= LINE_RST;
      deltaQ <= '0;
    end else begin
      if (stb.sampleLines) lineQ <= lineIn;
      deltaQ <= (stb.clrDelta ? '0 : deltaQ) | chg;
    end
  end

  always_comb begin
    loopView = '0;
    loopView[NLINES+LN_DCD] = ctrlQ[CB_OUT2];
    loopView[NLINES+LN_RI]  = ctrlQ[CB_OUT1];
    loopView[NLINES+LN_DSR] = ctrlQ[CB_DTR];
    loopView[NLINES+LN_CTS] = ctrlQ[CB_RTS];
  end

  always_comb begin
    if (!regSel)      rdData = {{(REG_W-CTRL_BITS){1'b0}}, ctrlQ};
    else if (loopMode) rdData = loopView;
    else               rdData = {lineQ, deltaQ};
  end

  assign dtrPin  = ctrlQ[CB_DTR]  & ~loopMode;
  assign rtsPin  = ctrlQ[CB_RTS]  & ~loopMode;
  assign out1Pin = ctrlQ[CB_OUT1] & ~loopMode;
  assign out2Pin = ctrlQ[CB_OUT2] & ~loopMode;

  p_ctrl_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCtrl |=> ctrlQ == $past(wrData[CTRL_BITS-1:0]));

  p_cts_change_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sampleLines && (lineQ[LN_CTS] != lineIn[LN_CTS])) |=> deltaQ[LN_CTS]);

  p_ri_rise_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sampleLines && !lineQ[LN_RI] && lineIn[LN_RI] && !deltaQ[LN_RI]) |=> !deltaQ[LN_RI]);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrDelta && chg == '0) |=> deltaQ == '0);

  p_loop_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.sampleLines |=> lineQ == $past(lineQ));

  p_loop_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    loopMode |=> deltaQ == $past(deltaQ));
endmodule

// File: rtl/modem_line_unit.sv
module modem_line_unit
  import mdm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regSel,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  output logic [7:0] rdData,
  input  logic       msIntEn,
  input  logic       ctsIn,
  input  logic       dsrIn,
  input  logic       dcdIn,
  input  logic       riIn,
  output logic       rtsOut,
  output logic       dtrOut,
  output logic       out1Out,
  output logic       out2Out,
  output logic       msIrq
);
  mdmStrobe_t        stb;
  logic              loopMode;
  logic [NLINES-1:0] deltaQ;
  logic [NLINES-1:0] lineIn;

  always_comb begin
    lineIn = '0;
    lineIn[LN_CTS] = ctsIn;
    lineIn[LN_DSR] = dsrIn;
    lineIn[LN_RI]  = riIn;
    lineIn[LN_DCD] = dcdIn;
  end

  mdm_control ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .regSel(regSel), .loopMode(loopMode), .stb(stb)
  );

  mdm_datapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .regSel(regSel), .wrData(wrData),
    .lineIn(lineIn), .rdData(rdData), .loopMode(loopMode), .deltaQ(deltaQ),
    .dtrPin(dtrOut), .rtsPin(rtsOut), .out1Pin(out1Out), .out2Pin(out2Out)
  );

  assign msIrq = msIntEn & (|deltaQ);

  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !msIntEn |-> !msIrq);

  p_loop_pins_r8: assert property (@(posedge clk) disable iff (!rstN)
    loopMode |-> !(rtsOut || dtrOut || out1Out || out2Out));
endmodule

// File: tb/modem_line_unit_tb.sv
module modem_line_unit_tb_top;
  logic clk = 0;
  logic rstN = 0;
  logic regSel = 0, wrEn = 0, rdEn = 0, msIntEn = 0;
  logic [7:0] wrData = 0;
  logic ctsIn = 1, dsrIn = 1, dcdIn = 1, riIn = 0;
  logic [7:0] rdData;
  logic rtsOut, dtrOut, out1Out, out2Out, msIrq;
  int checks = 0, errors = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  modem_line_unit dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .msIntEn(msIntEn), .ctsIn(ctsIn),
    .dsrIn(dsrIn), .dcdIn(dcdIn), .riIn(riIn), .rtsOut(rtsOut),
    .dtrOut(dtrOut), .out1Out(out1Out), .out2Out(out2Out), .msIrq(msIrq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wrCtrl(input logic [7:0] d);
    @(negedge clk); regSel = 0; wrEn = 1; wrData = d;
    @(negedge clk); wrEn = 0; #1;
  endtask

  task automatic rdReg(input logic sel, output logic [7:0] d);
    @(negedge clk); regSel = sel; rdEn = 1; #1 d = rdData;
    @(negedge clk); rdEn = 0; #1;
  endtask

  task automatic stepLines();
    @(negedge clk); #1;
  endtask

  task automatic tReset();
    rdReg(1, v); chk("R1 status", v, 8'hB0);
    rdReg(0, v); chk("R1 control", v, 8'h08);
    chk("R1 pins", {4'b0, out2Out, out1Out, rtsOut, dtrOut}, 8'h08);
    chk("R1 irq", {7'b0, msIrq}, 8'h00);
  endtask

  task automatic tCtrl();
    wrCtrl(8'hEF);
    rdReg(0, v); chk("R2 masked", v, 8'h0F);
    chk("R2 pins all", {4'b0, out2Out, out1Out, rtsOut, dtrOut}, 8'h0F);
    wrCtrl(8'h05);
    chk("R2 pins dtr out1", {4'b0, out2Out, out1Out, rtsOut, dtrOut}, 8'h05);
    wrCtrl(8'h02);
    chk("R2 pins rts", {4'b0, out2Out, out1Out, rtsOut, dtrOut}, 8'h02);
    wrCtrl(8'h08);
  endtask

  task automatic tDelta();
    @(negedge clk); ctsIn = 0; stepLines();
    rdReg(1, v); chk("R4 cts flag", v, 8'hA1);
    rdReg(1, v); chk("R6 cleared", v, 8'hA0);
    @(negedge clk); dsrIn = 0; dcdIn = 0; stepLines();
    rdReg(1, v); chk("R3 R4 dsr dcd fall", v, 8'h0A);
    rdReg(1, v); chk("R3 levels low", v, 8'h00);
    @(negedge clk); ctsIn = 1; dsrIn = 1; dcdIn = 1; stepLines(); stepLines();
    rdReg(1, v); chk("R4 rise sticky", v, 8'hBB);
    rdReg(1, v); chk("R6 cleared again", v, 8'hB0);
  endtask

  task automatic tRing();
    @(negedge clk); riIn = 1; stepLines();
    rdReg(1, v); chk("R5 rise no flag", v, 8'hF0);
    @(negedge clk); riIn = 0; stepLines();
    rdReg(1, v); chk("R5 trailing edge", v, 8'hB4);
    rdReg(1, v); chk("R5 cleared", v, 8'hB0);
  endtask

  task automatic tSameEdge();
    @(negedge clk); regSel = 1; rdEn = 1; ctsIn = 0; #1 v = rdData;
    chk("R6 old value", v, 8'hB0);
    @(negedge clk); rdEn = 0; #1;
    rdReg(1, v); chk("R6 edge kept", v, 8'hA1);
    @(negedge clk); ctsIn = 1; stepLines();
    rdReg(1, v);
  endtask

  task automatic tIrq();
    msIntEn = 0;
    @(negedge clk); ctsIn = 0; stepLines();
    chk("R7 masked", {7'b0, msIrq}, 8'h00);
    msIntEn = 1; #1;
    chk("R7 raised", {7'b0, msIrq}, 8'h01);
    rdReg(1, v);
    chk("R7 cleared", {7'b0, msIrq}, 8'h00);
    @(negedge clk); ctsIn = 1; stepLines();
    chk("R7 raised again", {7'b0, msIrq}, 8'h01);
    rdReg(1, v);
    msIntEn = 0;
  endtask

  task automatic tLoop();
    msIntEn = 1;
    wrCtrl(8'h13);
    chk("R8 pins off", {4'b0, out2Out, out1Out, rtsOut, dtrOut}, 8'h00);
    @(negedge clk); ctsIn = 0; riIn = 1; stepLines();
    chk("R8 inputs ignored irq", {7'b0, msIrq}, 8'h00);
    rdReg(1, v); chk("R8 remap rts dtr", v, 8'h30);
    wrCtrl(8'h1C);
    rdReg(1, v); chk("R8 remap out1 out2", v, 8'hC0);
    @(negedge clk); ctsIn = 1; riIn = 0;
    wrCtrl(8'h08);
    stepLines();
    rdReg(1, v); chk("R8 no change recorded", v, 8'hB0);
    // flags from before loopback survive reads in loopback
    @(negedge clk); ctsIn = 0; stepLines();
    wrCtrl(8'h13);
    rdReg(1, v); chk("R8 loop read", v, 8'h30);
    rdReg(1, v);
    chk("R9 irq held", {7'b0, msIrq}, 8'h01);
    wrCtrl(8'h08);
    rdReg(1, v); chk("R9 flag kept", v, 8'hA1);
    @(negedge clk); ctsIn = 1; stepLines();
    rdReg(1, v);
    msIntEn = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tReset();
    tCtrl();
    tDelta();
    tRing();
    tSameEdge();
    tIrq();
    tLoop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule